// File: doc/BRIEF.md
# Divided Multiphase Clock Generator

This block turns a fast oscillator into a set of four phase-related clock outputs. It has two stages. A decade prescaler first slows the oscillator by 1, 10 or 100. A phase sequencer then spreads the prescaled clock across four outputs in one of three arrangements:

- **Complementary pair.** No further division.
- **Three-phase rotation.** Divides by 3.
- **Four-phase quadrature set.** Divides by 4.

The output frequency is therefore the oscillator frequency divided by N times M, with N in {1, 10, 100} and M in {1, 3, 4}.

The design is fully synchronous. The time base is the input `clk`, and one `clk` cycle stands for one half-period of the oscillator. This lets the divide-by-1 path still produce a true 50% square wave at the full oscillator rate. As a result, a prescaled clock of ratio N toggles every N `clk` cycles.

The two select inputs are sampled only while the synchronous reset `rst` is high. A new prescale ratio or phase arrangement therefore takes effect after a reset, which also realigns the counters. The sequencer is a single enumerated state machine with these states:

- `ST_HOLD`: after reset, all outputs low.
- `ST_TWO`: the complementary-pair arrangement.
- `ST_P3_1`, `ST_P3_2`, `ST_P3_3`: the three-phase rotation.
- `ST_P4_START`, `ST_P4_12`, `ST_P4_23`, `ST_P4_34`, `ST_P4_41`: the quadrature set, including a start-up state.

Every transition happens on a rising edge of the prescaled clock. `ST_HOLD` leaves to the entry state of the latched arrangement. The three-phase states advance 1→2→3→1. The quadrature states advance START→12→23→34→41→12. `ST_TWO` stays where it is.

Top module: `mpc_clkgen`

## Requirements
- R1: While `rst` is high and after it falls, all four outputs are 0 until the first rising edge of the prescaled clock. That edge comes after `clk` edge N, counting the first edge with `rst` low as edge 1.
- R2: Divider select 00 gives N=1, 01 gives N=10, 10 gives N=100 and 11 also gives N=100. The prescaled clock is a 50% square wave that toggles every N `clk` cycles.
- R3: With phase select 00 (complementary pair), `phase_out[0]` equals the prescaled clock and `phase_out[1]` is its complement. `phase_out[2]` copies `phase_out[0]` and `phase_out[3]` copies `phase_out[1]`.
- R4: With phase select 01 (three-phase), exactly one of `phase_out[2:0]` is high at a time. Each output is high for 2N of every 6N cycles, the high output moves 0→1→2→0, and `phase_out[3]` stays 0.
- R5: With phase select 10 (four-phase), each output is high for 4N of every 8N cycles. Each output rises 2N cycles after the output below it, in the order 0,1,2,3.
- R6: In four-phase operation after the start-up interval, `phase_out[2]` is the complement of `phase_out[0]` and `phase_out[3]` is the complement of `phase_out[1]`.
- R7: In three-phase and four-phase operation, no two outputs rise on the same `clk` edge.
- R8: Changes on `div_sel` or `phase_sel` while `rst` is low have no effect on the outputs.
- R9: Phase select 11 behaves exactly like 10 (four-phase).
- R10: In three-phase and four-phase operation, `phase_out[0]` is the first output to rise after reset. In four-phase it is the only high output for the first 2N cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time base; one cycle is one oscillator half-period |
| rst | input | 1 | Synchronous active-high reset; select inputs are sampled while high |
| div_sel | input | 2 | Prescale ratio select (00 /1, 01 /10, 10 and 11 /100) |
| phase_sel | input | 2 | Phase arrangement select (00 pair, 01 three, 10 and 11 four) |
| phase_out | output | 4 | Generated phase outputs; bit 0 is the first phase |

## Verification
The checker watches several properties on every cycle:
- In three-phase mode, at most one output is high and bit 3 stays low.
- In the complementary-pair mode, the copy and complement relations hold.
- In four-phase mode, the opposite-output complement holds once start-up is over.
- In the shaped modes, no two outputs rise together.
- The latched mode never changes outside reset.

The exact prescale ratios, duty cycles, the 2N lag between phases, the start-up order and the blindness to select changes during a run are shown only by the scoreboard. It compares every output cycle against a model computed from the edge count.

// File: rtl/mpc_pkg.sv
package mpc_pkg;

    typedef enum logic [1:0] {
        DIV_1   = 2'd0,
        DIV_10  = 2'd1,
        DIV_100 = 2'd2
    } div_e;

    typedef enum logic [1:0] {
        PH_TWO   = 2'd0,
        PH_THREE = 2'd1,
        PH_FOUR  = 2'd2
    } ph_e;

    typedef enum logic [3:0] {
        ST_HOLD,
        ST_TWO,
        ST_P3_1,
        ST_P3_2,
        ST_P3_3,
        ST_P4_START,
        ST_P4_12,
        ST_P4_23,
        ST_P4_34,
        ST_P4_41
    } st_e;

    // Code 11 folds onto the last legal ratio
    function automatic div_e decode_div(input logic [1:0] code);
        div_e d;
        unique case (code)
            2'b00:   d = DIV_1;
            2'b01:   d = DIV_10;
            default: d = DIV_100;
        endcase
        return d;
    endfunction

    // Code 11 folds onto the last legal arrangement
    function automatic ph_e decode_ph(input logic [1:0] code);
        ph_e p;
        unique case (code)
            2'b00:   p = PH_TWO;
            2'b01:   p = PH_THREE;
            default: p = PH_FOUR;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/mpc_mode_latch.sv
module mpc_mode_latch
    import mpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] div_sel,
    input  logic [1:0] phase_sel,
    output div_e       div_mode,
    output ph_e        ph_mode
);

    // Selects are captured only while reset is held
    always_ff @(posedge clk) begin
        if (rst) begin
            div_mode <= decode_div(div_sel);
            ph_mode  <= decode_ph(phase_sel);
        end
    end

endmodule

// File: rtl/mpc_prescaler.sv
module mpc_prescaler
    import mpc_pkg::*;
#(
    parameter int DIV_MID = 10,
    parameter int DIV_HI  = 100
) (
    input  logic clk,
    input  logic rst,
    input  div_e div_mode,
    output logic div_lvl,
    output logic div_rise
);

    localparam int CW = (DIV_HI > 1) ? $clog2(DIV_HI) : 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;
    logic          wrap;

    // Half-count toggling gives a 50% prescaled clock
    always_comb begin
        unique case (div_mode)
            DIV_1:   lim = '0;
            DIV_10:  lim = CW'(DIV_MID - 1);
            default: lim = CW'(DIV_HI - 1);
        endcase
    end

    assign wrap     = (cnt == lim);
    assign div_rise = wrap & ~div_lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            div_lvl <= 1'b0;
        end else if (wrap) begin
            cnt     <= '0;
            div_lvl <= ~div_lvl;
        end else begin
            cnt     <= cnt + CW'(1);
        end
    end

endmodule

// File: rtl/mpc_phase_fsm.sv
module mpc_phase_fsm
    import mpc_pkg::*;
#(
    parameter int NOUT = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  ph_e             ph_mode,
    input  logic            div_lvl,
    input  logic            div_rise,
    output logic [NOUT-1:0] phase_out
);

    st_e state;
    st_e nxt;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_HOLD;
        else     state <= nxt;
    end

    // Transitions, taken only on a prescaled rising edge
    always_comb begin
        nxt = state;
        if (div_rise) begin
            unique case (state)
                ST_HOLD: begin
                    unique case (ph_mode)
                        PH_TWO:   nxt = ST_TWO;
                        PH_THREE: nxt = ST_P3_1;
                        default:  nxt = ST_P4_START;
                    endcase
                end
                ST_TWO:      nxt = ST_TWO;
                ST_P3_1:     nxt = ST_P3_2;
                ST_P3_2:     nxt = ST_P3_3;
                ST_P3_3:     nxt = ST_P3_1;
                ST_P4_START: nxt = ST_P4_12;
                ST_P4_12:    nxt = ST_P4_23;
                ST_P4_23:    nxt = ST_P4_34;
                ST_P4_34:    nxt = ST_P4_41;
                ST_P4_41:    nxt = ST_P4_12;
                default:     nxt = ST_HOLD;
            endcase
        end
    end

    // Output decode
    always_comb begin
        phase_out = '0;
        unique case (state)
            ST_HOLD:     phase_out[3:0] = 4'b0000;
            ST_TWO:      phase_out[3:0] = {~div_lvl, div_lvl, ~div_lvl, div_lvl};
            ST_P3_1:     phase_out[3:0] = 4'b0001;
            ST_P3_2:     phase_out[3:0] = 4'b0010;
            ST_P3_3:     phase_out[3:0] = 4'b0100;
            ST_P4_START: phase_out[3:0] = 4'b0001;
            ST_P4_12:    phase_out[3:0] = 4'b0011;
            ST_P4_23:    phase_out[3:0] = 4'b0110;
            ST_P4_34:    phase_out[3:0] = 4'b1100;
            ST_P4_41:    phase_out[3:0] = 4'b1001;
            default:     phase_out[3:0] = 4'b0000;
        endcase
    end

endmodule

// File: rtl/mpc_clkgen.sv
module mpc_clkgen
    import mpc_pkg::*;
#(
    parameter int DIV_MID = 10,
    parameter int DIV_HI  = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] div_sel,
    input  logic [1:0] phase_sel,
    output logic [3:0] phase_out
);

    div_e div_q;
    ph_e  ph_q;
    logic div_lvl;
    logic div_rise;

    mpc_mode_latch u_mode (
        .clk       (clk),
        .rst       (rst),
        .div_sel   (div_sel),
        .phase_sel (phase_sel),
        .div_mode  (div_q),
        .ph_mode   (ph_q)
    );

    mpc_prescaler #(
        .DIV_MID (DIV_MID),
        .DIV_HI  (DIV_HI)
    ) u_pre (
        .clk      (clk),
        .rst      (rst),
        .div_mode (div_q),
        .div_lvl  (div_lvl),
        .div_rise (div_rise)
    );

    mpc_phase_fsm #(
        .NOUT (4)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ph_mode   (ph_q),
        .div_lvl   (div_lvl),
        .div_rise  (div_rise),
        .phase_out (phase_out)
    );

endmodule

// File: rtl/mpc_clkgen_chk.sv
module mpc_clkgen_chk
    import mpc_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input div_e       div_mode,
    input ph_e        ph_mode,
    input logic [3:0] phase_out
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (phase_out == 4'b0000));

    // R3
    pair_relation_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_mode == PH_TWO && phase_out != 4'b0000) |->
            (phase_out[1] == ~phase_out[0] && phase_out[2] == phase_out[0]
             && phase_out[3] == phase_out[1]));

    // R4
    three_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_mode == PH_THREE) |-> ($onehot0(phase_out) && !phase_out[3]));

    // R6
    quad_complement_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_mode == PH_FOUR && phase_out != 4'b0000 && phase_out != 4'b0001) |->
            (phase_out[2] == ~phase_out[0] && phase_out[3] == ~phase_out[1]));

    // R7
    single_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_mode != PH_TWO) |->
            ($countones(phase_out & ~$past(phase_out)) <= 1));

    // R8
    mode_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ($stable(ph_mode) && $stable(div_mode)));

endmodule

bind mpc_clkgen mpc_clkgen_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .div_mode  (div_q),
    .ph_mode   (ph_q),
    .phase_out (phase_out)
);

// File: tb/tb_mpc_clkgen.sv
module tb_mpc_clkgen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] div_sel = 2'b00;
    logic [1:0] phase_sel = 2'b00;
    logic [3:0] phase_out;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    typedef struct {
        logic [3:0] exp;
        string      tag;
    } item_t;

    item_t sbq[$];

    always #2 clk = ~clk;

    mpc_clkgen dut (
        .clk       (clk),
        .rst       (rst),
        .div_sel   (div_sel),
        .phase_sel (phase_sel),
        .phase_out (phase_out)
    );

    function automatic int ratio(input logic [1:0] d);
        if (d == 2'b00) return 1;
        if (d == 2'b01) return 10;
        return 100;
    endfunction

    // Model computed from the requirements; e counts edges since reset release
    function automatic logic [3:0] model(input logic [1:0] ps, input int n, input int e);
        int k;
        logic l;
        if (e < n) return 4'b0000;
        if (ps == 2'b00) begin
            l = ((e / n) % 2) == 1;
            return {~l, l, ~l, l};
        end
        k = (e - n) / (2 * n);
        if (ps == 2'b01) return 4'(1 << (k % 3));
        if (k == 0) return 4'b0001;
        case (k % 4)
            1: return 4'b0011;
            2: return 4'b0110;
            3: return 4'b1100;
            default: return 4'b1001;
        endcase
    endfunction

    task automatic push(input logic [3:0] e, input string t);
        item_t it;
        it.exp = e;
        it.tag = t;
        sbq.push_back(it);
    endtask

    task automatic run_case(input logic [1:0] ds, input logic [1:0] ps,
                            input int edges, input int chg_at, input string tag);
        int n;
        n = ratio(ds);
        @(negedge clk);
        rst = 1'b1;
        div_sel = ds;
        phase_sel = ps;
        repeat (2) begin
            @(posedge clk);
            push(4'b0000, "R1");
        end
        @(negedge clk);
        rst = 1'b0;
        for (int e = 1; e <= edges; e++) begin
            @(posedge clk);
            if (e < n)
                push(model(ps, n, e), "R1");
            else if (ps != 2'b00 && e < 3 * n)
                push(model(ps, n, e), {tag, " R10"});
            else
                push(model(ps, n, e), tag);
            if (e == chg_at) begin
                @(negedge clk);
                div_sel = ~ds;
                phase_sel = ~ps;
            end
        end
    endtask

    // Monitor: compare one expected item per cycle at the falling edge
    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            item_t it;
            it = sbq.pop_front();
            checks++;
            if (phase_out !== it.exp) begin
                errors++;
                $display("FAIL %s: phase_out=%b expected=%b at %0t",
                         it.tag, phase_out, it.exp, $time);
            end
        end
    end

    initial begin
        run_case(2'b00, 2'b00,   40,  0, "R3");
        run_case(2'b01, 2'b00,  100,  0, "R2 R3");
        run_case(2'b10, 2'b00,  500,  0, "R2 R3");
        run_case(2'b11, 2'b00,  500,  0, "R2");
        run_case(2'b00, 2'b01,   60,  0, "R4 R7");
        run_case(2'b01, 2'b01,  200,  0, "R4 R7");
        run_case(2'b00, 2'b10,   60,  0, "R5 R6 R7");
        run_case(2'b01, 2'b10,  300,  0, "R5 R6");
        run_case(2'b10, 2'b10, 1000,  0, "R5 R6");
        run_case(2'b01, 2'b11,  200,  0, "R9");
        run_case(2'b01, 2'b01,  200, 37, "R8");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule